// File: doc/BRIEF.md
# Two-Level Hardware Page Table Walker

This block handles TLB refill misses without software help. The pipeline hands it a faulting virtual address over a ready/valid miss port. The block reads the top-level directory entry from memory, starting at a programmable directory base. It reads any optional intermediate directory levels that are configured, then reads two adjacent page-table words. Each of those words is shifted right by a programmable amount and becomes an entry-low value. The block then issues one TLB write carrying the even and odd entries together with the entry-high tag.

Some walks cannot complete: the walker may be disabled, a memory read may return an error, or a directory entry may be empty. In each of these cases the walker raises a fallback refill exception that carries the faulting address, so that the software handler can take over.

Software configures the walker through four registers: the directory base, the index shift fields, the index width fields, and a control register that holds the enable bit. Software clears the enable bit whenever it needs exclusive use of the entry-high register, and sets it again afterwards.

Top module: `pt_walker`

## Requirements
- R1: After reset, the base register, the width register and the control register read 0. The shift register reads all four index shifts as 12 and the PTE shift as 0, which is 0x0C30C300. The walker is idle with miss_ready high.
- R2: The shift register (select 1) is laid out as global shift [29:24], upper shift [23:18], middle shift [17:12], page-table shift [11:6] and PTE shift [5:0]. A write in which any of the four index shifts is below 12 is dropped entirely, and the register keeps its previous value.
- R3: A written PTE shift greater than PTE_SHIFT_MAX is not kept: that field holds its prior value, while the other fields of the same write still take effect.
- R4: A directory read goes to table base + 4 × ((va >> shift) & (2^width − 1)). The even page-table read goes to table base + 8 × page-table index, and the odd read goes to that address + 4. The width register (select 2) holds global width [19:15], upper width [14:10], middle width [9:5] and page-table width [4:0].
- R5: An upper or middle level whose width is 0 is skipped. A two-level walk makes exactly 3 memory reads, and a walk with a nonzero middle width makes 4.
- R6: A successful walk produces exactly one tlb_we pulse. On it, tlb_lo0 is the even word shifted right by the PTE shift, tlb_lo1 is the odd word shifted the same way, and tlb_hi is the faulting address with all bits below the page-table shift cleared.
- R7: When the enable bit (control bit 0) is clear, a miss is accepted, no memory read is made, and refill_exc pulses in the cycle after acceptance.
- R8: Clearing enable during a walk abandons the walk at its next state boundary: no TLB write occurs and refill_exc is raised. Setting enable again lets later walks complete.
- R9: A memory response with the error flag set abandons the walk and raises refill_exc, with no TLB write.
- R10: A directory entry whose value is zero abandons the walk and raises refill_exc, with no further read.
- R11: miss_ready is high only while the walker is idle, and it is low while a walk is in progress.
- R12: refill_va carries the faulting virtual address while refill_exc is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 shift, 2 width, 3 control |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected register |
| miss_valid | input | 1 | Refill miss request |
| miss_ready | output | 1 | Walker idle and able to take a miss |
| miss_va | input | 32 | Faulting virtual address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical read address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 32 | Read response word |
| mem_rsp_err | input | 1 | Read response error |
| tlb_we | output | 1 | TLB write pulse |
| tlb_hi | output | 32 | Entry-high tag for the write |
| tlb_lo0 | output | 32 | Even entry-low value |
| tlb_lo1 | output | 32 | Odd entry-low value |
| refill_exc | output | 1 | Fallback refill exception pulse |
| refill_va | output | 32 | Faulting address for the exception |

## Verification
The bench builds the walker with its defaults, PTE_SHIFT_MAX = 8 and a minimum index shift of 12. With these values, a PTE shift of 2 is accepted, and both a PTE shift of 40 and a global shift of 11 fall into the rejected ranges. The bench then programs a global shift of 22 and a page-table shift of 13, with 4-bit widths. These settings place directory and page tables inside a small memory model, where an out-of-range pointer produces a read error. They also let one walk switch on a 4-bit middle level (shift 17), so that the skipped-level and extra-level paths are both reached. A three-cycle memory latency leaves room to clear the enable bit while a read is still outstanding.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int WORD_W = 32;
    localparam int SH_W   = 6;
    localparam int WD_W   = 5;

    // Index shift register: field positions are software visible
    typedef struct packed {
        logic [1:0]      rsvd;
        logic [SH_W-1:0] gd;
        logic [SH_W-1:0] ud;
        logic [SH_W-1:0] md;
        logic [SH_W-1:0] pt;
        logic [SH_W-1:0] pte;
    } shift_cfg_t;

    typedef struct packed {
        logic [11:0]     rsvd;
        logic [WD_W-1:0] gd;
        logic [WD_W-1:0] ud;
        logic [WD_W-1:0] md;
        logic [WD_W-1:0] pt;
    } width_cfg_t;

    typedef enum logic [1:0] {SEL_BASE, SEL_SHIFT, SEL_WIDTH, SEL_CTRL} cfg_sel_e;

    typedef enum logic [2:0] {LV_GD, LV_UD, LV_MD, LV_PTE_EVEN, LV_PTE_ODD} level_e;

    typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_WRITE, ST_FAIL} state_e;

    function automatic logic [VA_W-1:0] field_index(logic [VA_W-1:0] va,
                                                    logic [SH_W-1:0] sh,
                                                    logic [WD_W-1:0] wd);
        logic [63:0] shifted;
        logic [63:0] mask;
        shifted = {{(64-VA_W){1'b0}}, va} >> sh;
        mask    = (64'd1 << wd) - 64'd1;
        shifted = shifted & mask;
        return shifted[VA_W-1:0];
    endfunction

endpackage

// File: rtl/ptw_cfg.sv
module ptw_cfg
    import ptw_pkg::*;
#(
    parameter int PTE_SHIFT_MAX   = 8,
    parameter int RESET_IDX_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [PA_W-1:0]   base,
    output shift_cfg_t        shifts,
    output width_cfg_t        widths,
    output logic              enable
);
    localparam logic [SH_W-1:0] MIN_SH  = SH_W'(RESET_IDX_SHIFT);
    localparam logic [SH_W-1:0] PTE_MAX = SH_W'(PTE_SHIFT_MAX);

    shift_cfg_t wr_shift;
    shift_cfg_t shift_next;
    logic       shift_ok;

    always_comb begin
        wr_shift = shift_cfg_t'(wdata);
        shift_ok = (wr_shift.gd >= MIN_SH) && (wr_shift.ud >= MIN_SH) &&
                   (wr_shift.md >= MIN_SH) && (wr_shift.pt >= MIN_SH);
        shift_next      = wr_shift;
        shift_next.rsvd = '0;
        if (wr_shift.pte > PTE_MAX) shift_next.pte = shifts.pte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base   <= '0;
            shifts <= '{rsvd: '0, gd: MIN_SH, ud: MIN_SH, md: MIN_SH, pt: MIN_SH, pte: '0};
            widths <= '0;
            enable <= 1'b0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_BASE:  base <= wdata[PA_W-1:0];
                SEL_SHIFT: if (shift_ok) shifts <= shift_next;
                SEL_WIDTH: widths <= {12'b0, wdata[19:0]};
                SEL_CTRL:  enable <= wdata[0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (cfg_sel_e'(sel))
            SEL_BASE:  rdata = base;
            SEL_SHIFT: rdata = shifts;
            SEL_WIDTH: rdata = widths;
            default:   rdata = {{(WORD_W-1){1'b0}}, enable};
        endcase
    end

    // R2: index shifts never fall below the floor
    a_r2_idx_shift_floor: assert property (@(posedge clk) disable iff (rst)
        (shifts.gd >= MIN_SH) && (shifts.ud >= MIN_SH) &&
        (shifts.md >= MIN_SH) && (shifts.pt >= MIN_SH));

    // R3: stored PTE shift stays in the supported range
    a_r3_pte_shift_bounded: assert property (@(posedge clk) disable iff (rst)
        shifts.pte <= PTE_MAX);

endmodule

// File: rtl/ptw_index.sv
module ptw_index
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  shift_cfg_t      shifts,
    input  width_cfg_t      widths,
    input  level_e          level,
    input  logic [PA_W-1:0] ptr,
    output logic [PA_W-1:0] fetch_addr,
    output logic [VA_W-1:0] hi_tag
);
    logic [VA_W-1:0] idx;
    logic [63:0]     low_mask;

    always_comb begin
        case (level)
            LV_GD:   idx = field_index(va, shifts.gd, widths.gd);
            LV_UD:   idx = field_index(va, shifts.ud, widths.ud);
            LV_MD:   idx = field_index(va, shifts.md, widths.md);
            default: idx = field_index(va, shifts.pt, widths.pt);
        endcase
        case (level)
            LV_PTE_EVEN: fetch_addr = ptr + (idx << 3);
            LV_PTE_ODD:  fetch_addr = ptr + (idx << 3) + PA_W'(4);
            default:     fetch_addr = ptr + (idx << 2);
        endcase
        low_mask = (64'd1 << shifts.pt) - 64'd1;
        hi_tag   = va & ~low_mask[VA_W-1:0];
    end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [PA_W-1:0]   base,
    input  logic              ud_on,
    input  logic              md_on,
    input  logic [SH_W-1:0]   pte_shift,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VA_W-1:0]   miss_va,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    input  logic [PA_W-1:0]   fetch_addr,
    output level_e            level,
    output logic [PA_W-1:0]   ptr,
    output logic [VA_W-1:0]   va_q,
    output logic              tlb_we,
    output logic [WORD_W-1:0] tlb_lo0,
    output logic [WORD_W-1:0] tlb_lo1,
    output logic              refill_exc
);
    state_e state;

    function automatic level_e after_dir(level_e lv, logic u, logic m);
        case (lv)
            LV_GD:   return u ? LV_UD : (m ? LV_MD : LV_PTE_EVEN);
            LV_UD:   return m ? LV_MD : LV_PTE_EVEN;
            default: return LV_PTE_EVEN;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            level   <= LV_GD;
            ptr     <= '0;
            va_q    <= '0;
            tlb_lo0 <= '0;
            tlb_lo1 <= '0;
        end else begin
            case (state)
                ST_IDLE: if (miss_valid) begin
                    va_q  <= miss_va;
                    ptr   <= base;
                    level <= LV_GD;
                    state <= enable ? ST_REQ : ST_FAIL;
                end
                ST_REQ: begin
                    if (!enable)            state <= ST_FAIL;
                    else if (mem_req_ready) state <= ST_WAIT;
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err || !enable) begin
                        state <= ST_FAIL;
                    end else begin
                        case (level)
                            LV_PTE_EVEN: begin
                                tlb_lo0 <= mem_rsp_data >> pte_shift;
                                level   <= LV_PTE_ODD;
                                state   <= ST_REQ;
                            end
                            LV_PTE_ODD: begin
                                tlb_lo1 <= mem_rsp_data >> pte_shift;
                                state   <= ST_WRITE;
                            end
                            default: begin
                                if (mem_rsp_data == '0) begin
                                    state <= ST_FAIL;
                                end else begin
                                    ptr   <= mem_rsp_data[PA_W-1:0];
                                    level <= after_dir(level, ud_on, md_on);
                                    state <= ST_REQ;
                                end
                            end
                        endcase
                    end
                end
                ST_WRITE: state <= enable ? ST_IDLE : ST_FAIL;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign miss_ready    = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_REQ) && enable;
    assign tlb_we        = (state == ST_WRITE) && enable;
    assign refill_exc    = (state == ST_FAIL);

    // R11: no new miss is taken while a read is outstanding
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !miss_ready);

    // R7: a miss taken while disabled falls back on the next cycle
    a_r7_disabled_fallback: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready && !enable) |=> refill_exc);

    // R9: an errored response ends the walk in the fallback
    a_r9_error_fallback: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && mem_rsp_valid && mem_rsp_err) |=> refill_exc);

    // R6: a TLB write closes the walk and frees the miss port
    a_r6_write_returns_idle: assert property (@(posedge clk) disable iff (rst)
        tlb_we |=> (miss_ready && !tlb_we));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int PTE_SHIFT_MAX   = 8,
    parameter int RESET_IDX_SHIFT = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        miss_valid,
    output logic        miss_ready,
    input  logic [31:0] miss_va,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    input  logic        mem_rsp_err,
    output logic        tlb_we,
    output logic [31:0] tlb_hi,
    output logic [31:0] tlb_lo0,
    output logic [31:0] tlb_lo1,
    output logic        refill_exc,
    output logic [31:0] refill_va
);
    logic [PA_W-1:0] base;
    shift_cfg_t      shifts;
    width_cfg_t      widths;
    logic            enable;
    level_e          level;
    logic [PA_W-1:0] ptr;
    logic [PA_W-1:0] fetch_addr;
    logic [VA_W-1:0] va_q;
    logic [VA_W-1:0] hi_tag;

    ptw_cfg #(
        .PTE_SHIFT_MAX  (PTE_SHIFT_MAX),
        .RESET_IDX_SHIFT(RESET_IDX_SHIFT)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .base(base), .shifts(shifts), .widths(widths),
        .enable(enable)
    );

    ptw_index u_index (
        .va(va_q), .shifts(shifts), .widths(widths), .level(level), .ptr(ptr),
        .fetch_addr(fetch_addr), .hi_tag(hi_tag)
    );

    ptw_fsm u_fsm (
        .clk(clk), .rst(rst), .enable(enable), .base(base),
        .ud_on(widths.ud != '0), .md_on(widths.md != '0), .pte_shift(shifts.pte),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_va(miss_va),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .fetch_addr(fetch_addr), .level(level),
        .ptr(ptr), .va_q(va_q), .tlb_we(tlb_we), .tlb_lo0(tlb_lo0),
        .tlb_lo1(tlb_lo1), .refill_exc(refill_exc)
    );

    assign mem_req_addr = fetch_addr;
    assign tlb_hi       = hi_tag;
    assign refill_va    = va_q;

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [31:0] miss_va = 32'd0;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid, mem_rsp_err;
    logic [31:0] mem_rsp_data;
    logic        tlb_we, refill_exc;
    logic [31:0] tlb_hi, tlb_lo0, tlb_lo1, refill_va;

    always #2 clk = ~clk;

    pt_walker u_pt_walker (.*);

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;

    // Memory model: 1 KB, three-cycle latency, error above 0x3FF
    logic [31:0] mem [0:255];
    logic        pend;
    logic [31:0] paddr;
    int          lat;
    int          rd_cnt = 0;
    logic [31:0] req_log [0:7];

    assign mem_req_ready = !pend;
    assign mem_rsp_valid = pend && (lat == 0);
    assign mem_rsp_err   = paddr >= 32'h400;
    assign mem_rsp_data  = (paddr < 32'h400) ? mem[paddr[9:2]] : 32'd0;

    always @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            paddr <= 32'd0;
            lat   <= 0;
        end else if (mem_req_valid && !pend) begin
            pend   <= 1'b1;
            paddr  <= mem_req_addr;
            lat    <= 2;
            req_log[rd_cnt % 8] <= mem_req_addr;
            rd_cnt <= rd_cnt + 1;
        end else if (pend) begin
            if (lat == 0) pend <= 1'b0;
            else lat <= lat - 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000 && !finished) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] shv(int gd, int ud, int md, int pt, int pte);
        return (gd << 24) | (ud << 18) | (md << 12) | (pt << 6) | pte;
    endfunction

    function automatic logic [31:0] wdv(int gd, int ud, int md, int pt);
        return (gd << 15) | (ud << 10) | (md << 5) | pt;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    logic        r_wr, r_exc, r_busy_bad;
    logic [31:0] r_hi, r_lo0, r_lo1, r_va;

    task automatic send_miss(input logic [31:0] va);
        @(negedge clk);
        miss_valid = 1'b1; miss_va = va;
        @(posedge clk);
        #1 miss_valid = 1'b0;
    endtask

    task automatic wait_outcome();
        bit done = 0;
        r_wr = 0; r_exc = 0; r_busy_bad = 0;
        for (int i = 0; i < 100 && !done; i++) begin
            @(negedge clk);
            if (tlb_we) begin
                r_wr = 1; r_hi = tlb_hi; r_lo0 = tlb_lo0; r_lo1 = tlb_lo1; done = 1;
            end else if (refill_exc) begin
                r_exc = 1; r_va = refill_va; done = 1;
            end else if (miss_ready) begin
                r_busy_bad = 1;
            end
        end
        @(negedge clk);
        if (tlb_we || refill_exc) r_busy_bad = 1;
    endtask

    localparam logic [31:0] V_VA [0:4] = '{32'h0040A123, 32'hFC81FFFF, 32'h00401000,
                                           32'h00C00000, 32'h01402000};
    localparam logic [31:0] V_PT [0:4] = '{32'h100, 32'h200, 32'h100, 32'h0, 32'h0};
    localparam bit          V_EXC[0:4] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam int          V_RD [0:4] = '{3, 3, 3, 1, 2};

    initial begin
        logic [31:0] d, ev;
        int          start;
        for (int w = 0; w < 256; w++) mem[w] = 32'hA000_0000 | (w << 2);
        mem[1] = 32'h100; mem[2] = 32'h200; mem[3] = 32'h0;
        mem[5] = 32'h800; mem[6] = 32'h080; mem[35] = 32'h300;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cfg_read(2'd1, d); check(d == 32'h0C30C300, "R1 shift reset", d, 32'h0C30C300);
        cfg_read(2'd2, d); check(d == 32'd0, "R1 width reset", d, 0);
        cfg_read(2'd3, d); check(d == 32'd0, "R1 ctrl reset", d, 0);
        cfg_read(2'd0, d); check(d == 32'd0, "R1 base reset", d, 0);
        check(miss_ready == 1'b1, "R1 idle ready", {31'd0, miss_ready}, 1);

        // R2 whole write dropped when one index shift is below 12
        cfg_write(2'd1, shv(11, 12, 12, 13, 2));
        cfg_read(2'd1, d); check(d == 32'h0C30C300, "R2 rejected write", d, 32'h0C30C300);
        cfg_write(2'd1, shv(22, 12, 12, 13, 2));
        cfg_read(2'd1, d); check(d == shv(22, 12, 12, 13, 2), "R2 legal write", d, shv(22, 12, 12, 13, 2));

        // R3 unsupported PTE shift is not kept, other fields apply
        cfg_write(2'd1, shv(22, 12, 17, 13, 40));
        cfg_read(2'd1, d); check(d == shv(22, 12, 17, 13, 2), "R3 pte shift kept", d, shv(22, 12, 17, 13, 2));

        cfg_write(2'd2, wdv(4, 0, 0, 4));
        cfg_write(2'd0, 32'd0);

        // R7 disabled: immediate fallback, no reads
        start = rd_cnt;
        send_miss(32'h0040A123);
        wait_outcome();
        check(r_exc && !r_wr, "R7 disabled fallback", {30'd0, r_wr, r_exc}, 1);
        check(rd_cnt == start, "R7 no reads", rd_cnt - start, 0);
        check(r_va == 32'h0040A123, "R12 refill_va", r_va, 32'h0040A123);

        cfg_write(2'd3, 32'd1);

        // Vector table: R4 R5 R6 R9 R10 R11 R12
        for (int k = 0; k < 5; k++) begin
            start = rd_cnt;
            send_miss(V_VA[k]);
            wait_outcome();
            check(!r_busy_bad, "R11 busy/one outcome", {31'd0, r_busy_bad}, 0);
            check(rd_cnt - start == V_RD[k], "R5 read count", rd_cnt - start, V_RD[k]);
            if (V_EXC[k]) begin
                check(r_exc && !r_wr, "R9/R10 fallback", {30'd0, r_wr, r_exc}, 1);
                check(r_va == V_VA[k], "R12 refill_va", r_va, V_VA[k]);
            end else begin
                ev = V_PT[k] + (((V_VA[k] >> 13) & 32'hF) << 3);
                check(r_wr && !r_exc, "R6 write", {30'd0, r_wr, r_exc}, 2);
                check(r_lo0 == ((32'hA000_0000 | ev) >> 2), "R6 lo0", r_lo0, (32'hA000_0000 | ev) >> 2);
                check(r_lo1 == ((32'hA000_0000 | (ev + 4)) >> 2), "R6 lo1", r_lo1, (32'hA000_0000 | (ev + 4)) >> 2);
                check(r_hi == (V_VA[k] & ~32'h1FFF), "R6 hi", r_hi, V_VA[k] & ~32'h1FFF);
                check(req_log[start % 8] == (((V_VA[k] >> 22) & 32'hF) << 2), "R4 dir addr",
                      req_log[start % 8], ((V_VA[k] >> 22) & 32'hF) << 2);
                check(req_log[(start + 2) % 8] == ev + 4, "R4 odd addr", req_log[(start + 2) % 8], ev + 4);
            end
        end

        // R5 three-level walk through a middle directory
        cfg_write(2'd2, wdv(4, 0, 4, 4));
        start = rd_cnt;
        send_miss(32'h01864000);
        wait_outcome();
        check(rd_cnt - start == 4, "R5 middle level reads", rd_cnt - start, 4);
        check(r_lo0 == ((32'hA000_0000 | 32'h310) >> 2), "R5 middle level lo0", r_lo0, (32'hA000_0000 | 32'h310) >> 2);
        check(req_log[(start + 1) % 8] == 32'h08C, "R4 middle addr", req_log[(start + 1) % 8], 32'h08C);
        cfg_write(2'd2, wdv(4, 0, 0, 4));

        // R8 enable cleared during a walk
        start = rd_cnt;
        send_miss(32'h0040A123);
        cfg_write(2'd3, 32'd0);
        wait_outcome();
        check(r_exc && !r_wr, "R8 abort no write", {30'd0, r_wr, r_exc}, 1);
        check(rd_cnt - start == 1, "R8 abort reads", rd_cnt - start, 1);
        cfg_write(2'd3, 32'd1);
        send_miss(32'h0040A123);
        wait_outcome();
        check(r_wr && !r_exc, "R8 restart completes", {30'd0, r_wr, r_exc}, 2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule